// File: doc/BRIEF.md
# Microcoded Stack Pointer Unit

This block holds the 8-bit stack pointer of a small accumulator CPU together with the short microcode sequences that implement the stack side of seven instructions. They are: push accumulator, pull accumulator, call subroutine, return, load pointer from an immediate byte, copy accumulator to pointer, and copy pointer to accumulator. After a one-cycle start request with an operation code, the unit steps through a fixed number of microcycles. In each microcycle it emits memory address, read and write strobes, driver enables and load strobes for the accumulator and program counter, which live outside the block.

All data moves over one shared 8-bit bus. The pointer and a hidden call-target holding register drive that bus through tri-state outputs. The accumulator, the program counter and memory drive it from outside when the unit asserts their enables. The pointer grows upward: a push writes at the current pointer and then increments it, and a pull decrements first and then reads. The pointer therefore always addresses the free slot just above the top entry. The pointer has no reset and wraps silently at both ends.

Top module: `stack_unit`

## Requirements
- R1: Push accumulator (code 0) takes 1 cycle: it drives `mem_addr` with the pointer, asserts `acc_oe` and `mem_we`, and the pointer then increments by one.
- R2: Pull accumulator (code 1) takes 2 cycles: the pointer decrements in the first, and the second reads memory at the new pointer into the accumulator (`mem_rd`, `acc_ld`).
- R3: The pointer wraps silently: incrementing 0xFF gives 0x00 and decrementing 0x00 gives 0xFF.
- R4: Load immediate (code 4) takes 1 cycle: it reads memory at `pc_in` into the pointer and asserts `pc_inc`.
- R5: Accumulator-to-pointer (code 5) loads the pointer from the accumulator driven on the bus; pointer-to-accumulator (code 6) drives the pointer onto the bus with `acc_ld`. Each takes 1 cycle.
- R6: Call (code 2) takes 3 cycles: it reads the target at `pc_in` into a hidden register with `pc_inc`, then pushes the incremented program counter, then drives the hidden target onto the bus with `pc_ld`.
- R7: Return (code 3) takes 2 cycles: the pointer decrements, then memory at the new pointer is loaded into the program counter.
- R8: The unit drives `dbus` only while it outputs the pointer or the call target; at all other times its driver is high impedance, so outside sources reach the pointer uncorrupted.
- R9: `done` is high only in the last cycle of an instruction and `busy` in all of its cycles. A start request while busy, or with code 7, is ignored.
- R10: The pointer has no reset: `rst` leaves its value unchanged. While idle, `mem_addr` shows the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer only |
| start | input | 1 | Request to begin the operation on `op` |
| op | input | 3 | Operation code (0 push, 1 pull, 2 call, 3 return, 4 load immediate, 5 acc to pointer, 6 pointer to acc) |
| pc_in | input | 8 | Current program counter value |
| dbus | inout | 8 | Shared data bus |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | Memory write strobe (memory captures `dbus`) |
| mem_rd | output | 1 | Memory read enable (memory drives `dbus`) |
| acc_oe | output | 1 | Accumulator drives `dbus` |
| acc_ld | output | 1 | Accumulator loads `dbus` |
| pc_oe | output | 1 | Program counter drives `dbus` |
| pc_ld | output | 1 | Program counter loads `dbus` |
| pc_inc | output | 1 | Program counter increments |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Last cycle of the instruction |

## Verification
On every cycle, the assertions check that at most one bus source is enabled and that memory is never read and written together. They also check that the pointer wraps at both ends, that a load of the pointer takes the bus value, that the hidden target holds between loads, and that an instruction in progress keeps its code and ends one cycle after its last step. Only the bench scenarios can show the stack contents and ordering through the pre-decrement and post-increment rule, and the pushed return address of a call. They also cover the cycle counts per instruction, the pointer surviving a reset, and starts that arrive while busy or carry the unused code.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int unsigned SP_W  = 8;
    localparam int unsigned PH_W  = 2;

    typedef logic [SP_W-1:0] word_t;
    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [2:0] {
        OP_PUSH_A   = 3'd0,
        OP_PULL_A   = 3'd1,
        OP_CALL     = 3'd2,
        OP_RET      = 3'd3,
        OP_LOAD_IMM = 3'd4,
        OP_A_TO_SP  = 3'd5,
        OP_SP_TO_A  = 3'd6,
        OP_NONE     = 3'd7
    } stk_op_e;

    typedef enum logic {
        SEL_SP = 1'b0,
        SEL_PC = 1'b1
    } addr_sel_e;

    typedef struct packed {
        logic      sp_cnt;
        logic      sp_up;
        logic      sp_ld;
        logic      sp_oe;
        logic      tmp_ld;
        logic      tmp_oe;
        addr_sel_e asel;
        logic      mem_we;
        logic      mem_rd;
        logic      acc_oe;
        logic      acc_ld;
        logic      pc_oe;
        logic      pc_ld;
        logic      pc_inc;
        logic      last;
    } uop_t;

    function automatic phase_t op_len(stk_op_e op);
        case (op)
            OP_PULL_A, OP_RET: return 2'd2;
            OP_CALL:           return 2'd3;
            default:           return 2'd1;
        endcase
    endfunction

    function automatic logic op_valid(logic [2:0] code);
        return code != OP_NONE;
    endfunction

    function automatic uop_t decode_uop(stk_op_e op, phase_t ph);
        uop_t u;
        u = '0;
        u.asel = SEL_SP;
        case (op)
            OP_PUSH_A: begin
                u.acc_oe = 1'b1;
                u.mem_we = 1'b1;
                u.sp_cnt = 1'b1;
                u.sp_up  = 1'b1;
            end
            OP_PULL_A: begin
                if (ph == 2'd0) begin
                    u.sp_cnt = 1'b1;
                end else begin
                    u.mem_rd = 1'b1;
                    u.acc_ld = 1'b1;
                end
            end
            OP_CALL: begin
                if (ph == 2'd0) begin
                    u.asel   = SEL_PC;
                    u.mem_rd = 1'b1;
                    u.tmp_ld = 1'b1;
                    u.pc_inc = 1'b1;
                end else if (ph == 2'd1) begin
                    u.pc_oe  = 1'b1;
                    u.mem_we = 1'b1;
                    u.sp_cnt = 1'b1;
                    u.sp_up  = 1'b1;
                end else begin
                    u.tmp_oe = 1'b1;
                    u.pc_ld  = 1'b1;
                end
            end
            OP_RET: begin
                if (ph == 2'd0) begin
                    u.sp_cnt = 1'b1;
                end else begin
                    u.mem_rd = 1'b1;
                    u.pc_ld  = 1'b1;
                end
            end
            OP_LOAD_IMM: begin
                u.asel   = SEL_PC;
                u.mem_rd = 1'b1;
                u.sp_ld  = 1'b1;
                u.pc_inc = 1'b1;
            end
            OP_A_TO_SP: begin
                u.acc_oe = 1'b1;
                u.sp_ld  = 1'b1;
            end
            OP_SP_TO_A: begin
                u.sp_oe  = 1'b1;
                u.acc_ld = 1'b1;
            end
            default: u = '0;
        endcase
        u.last = (ph == op_len(op) - 2'd1);
        return u;
    endfunction

endpackage

// File: rtl/sp_counter.sv
module sp_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         cnt,
    input  logic         up,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    // No reset: the pointer keeps whatever it holds until software loads it.
    always_ff @(posedge clk) begin
        if (ld) begin
            q <= d;
        end else if (cnt) begin
            q <= up ? q + ONE : q - ONE;
        end
    end

    p_wrap_up_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt && !ld && up && q == '1) |=> (q == '0));

    p_wrap_down_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt && !ld && !up && q == '0) |=> (q == '1));

    p_load_wins_r5: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(d)));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!ld && !cnt && $past(!rst)) |=> $stable(q));
endmodule

// File: rtl/call_hold.sv
module call_hold #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (ld) begin
            q <= d;
        end
    end

    p_target_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (!ld && $past(!rst)) |=> $stable(q));
endmodule

// File: rtl/stk_sequencer.sv
module stk_sequencer
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] op,
    output uop_t       uop,
    output logic       busy
);
    logic    active_q;
    stk_op_e op_q;
    phase_t  ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            op_q     <= OP_NONE;
            ph_q     <= '0;
        end else if (!active_q) begin
            if (start && op_valid(op)) begin
                active_q <= 1'b1;
                op_q     <= stk_op_e'(op);
                ph_q     <= '0;
            end
        end else if (uop.last) begin
            active_q <= 1'b0;
            ph_q     <= '0;
        end else begin
            ph_q <= ph_q + 2'd1;
        end
    end

    always_comb begin
        uop = '0;
        if (active_q) begin
            uop = decode_uop(op_q, ph_q);
        end
    end

    assign busy = active_q;

    p_single_driver_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({uop.sp_oe, uop.tmp_oe, uop.acc_oe, uop.pc_oe, uop.mem_rd}));

    p_no_rd_wr_r1: assert property (@(posedge clk) disable iff (rst)
        !(uop.mem_we && uop.mem_rd));

    p_done_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && uop.last) |=> !busy);

    p_busy_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !uop.last) |=> (busy && op_q == $past(op_q)));

    p_phase_bound_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ph_q < op_len(op_q)));
endmodule

// File: rtl/stack_unit.sv
module stack_unit
    import stk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [SP_W-1:0] pc_in,
    inout  wire  [SP_W-1:0] dbus,
    output logic [SP_W-1:0] mem_addr,
    output logic            mem_we,
    output logic            mem_rd,
    output logic            acc_oe,
    output logic            acc_ld,
    output logic            pc_oe,
    output logic            pc_ld,
    output logic            pc_inc,
    output logic            busy,
    output logic            done
);
    uop_t  uop;
    word_t sp_q;
    word_t tmp_q;

    stk_sequencer i_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op),
        .uop   (uop),
        .busy  (busy)
    );

    sp_counter #(.W(SP_W)) i_sp (
        .clk (clk),
        .rst (rst),
        .ld  (uop.sp_ld),
        .cnt (uop.sp_cnt),
        .up  (uop.sp_up),
        .d   (dbus),
        .q   (sp_q)
    );

    call_hold #(.W(SP_W)) i_hold (
        .clk (clk),
        .rst (rst),
        .ld  (uop.tmp_ld),
        .d   (dbus),
        .q   (tmp_q)
    );

    assign dbus = uop.sp_oe  ? sp_q  :
                  uop.tmp_oe ? tmp_q : {SP_W{1'bz}};

    assign mem_addr = (uop.asel == SEL_PC) ? pc_in : sp_q;
    assign mem_we   = uop.mem_we;
    assign mem_rd   = uop.mem_rd;
    assign acc_oe   = uop.acc_oe;
    assign acc_ld   = uop.acc_ld;
    assign pc_oe    = uop.pc_oe;
    assign pc_ld    = uop.pc_ld;
    assign pc_inc   = uop.pc_inc;
    assign done     = uop.last;
endmodule

// File: tb/test_stack_unit.sv
`timescale 1ns/1ps
module test_stack_unit;
    import stk_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [2:0] op;
    logic [7:0] pc_r;
    logic [7:0] a_r;
    logic [7:0] ram [256];
    wire  [7:0] dbus;
    logic [7:0] mem_addr;
    logic mem_we, mem_rd, acc_oe, acc_ld, pc_oe, pc_ld, pc_inc, busy, done;

    logic [7:0] exp_sp, exp_a, exp_pc;
    logic [7:0] em [256];
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    stack_unit i_stack_unit (
        .clk(clk), .rst(rst), .start(start), .op(op), .pc_in(pc_r),
        .dbus(dbus), .mem_addr(mem_addr), .mem_we(mem_we), .mem_rd(mem_rd),
        .acc_oe(acc_oe), .acc_ld(acc_ld), .pc_oe(pc_oe), .pc_ld(pc_ld),
        .pc_inc(pc_inc), .busy(busy), .done(done)
    );

    // Environment: accumulator, program counter and memory on the shared bus.
    assign dbus = acc_oe ? a_r : pc_oe ? pc_r : mem_rd ? ram[mem_addr] : 8'hzz;

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= dbus;
        if (acc_ld) a_r <= dbus;
        if (pc_ld) pc_r <= dbus;
        else if (pc_inc) pc_r <= pc_r + 8'd1;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic int cycles_of(input logic [2:0] c);
        case (c)
            3'd1, 3'd3: return 2;
            3'd2:       return 3;
            default:    return 1;
        endcase
    endfunction

    task automatic model_step(input logic [2:0] c);
        logic [7:0] t;
        case (c)
            3'd0: begin em[exp_sp] = exp_a; exp_sp = exp_sp + 8'd1; end
            3'd1: begin exp_sp = exp_sp - 8'd1; exp_a = em[exp_sp]; end
            3'd2: begin
                t = em[exp_pc]; exp_pc = exp_pc + 8'd1;
                em[exp_sp] = exp_pc; exp_sp = exp_sp + 8'd1; exp_pc = t;
            end
            3'd3: begin exp_sp = exp_sp - 8'd1; exp_pc = em[exp_sp]; end
            3'd4: begin exp_sp = em[exp_pc]; exp_pc = exp_pc + 8'd1; end
            3'd5: exp_sp = exp_a;
            3'd6: exp_a = exp_sp;
            default: ;
        endcase
    endtask

    task automatic poke_a(input logic [7:0] v);
        a_r = v; exp_a = v;
    endtask

    task automatic poke_mem(input logic [7:0] ad, input logic [7:0] v);
        ram[ad] = v; em[ad] = v;
    endtask

    task automatic run_op(input logic [2:0] c, input bit junk);
        int n = 0;
        bit seen = 1'b0;
        int early = 0;
        string tg = tag_of(c);
        @(negedge clk);
        start = 1'b1; op = c;
        @(negedge clk);
        if (!junk) start = 1'b0;
        else op = 3'd5;
        while (!seen && n < 8) begin
            n++;
            if (!busy) early++;
            seen = done;
            @(negedge clk);
        end
        start = 1'b0;
        model_step(c);
        check(tg, "cycle count", n, cycles_of(c));
        check("R9", "busy in every step", early, 0);
        check(tg, "pointer", mem_addr, exp_sp);
        check(tg, "accumulator", a_r, exp_a);
        check(tg, "program counter", pc_r, exp_pc);
        if (c == 3'd0 || c == 3'd2)
            check(tg, "stacked byte", ram[exp_sp - 8'd1], em[exp_sp - 8'd1]);
        if (junk) check("R9", "busy after ignored start", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; op = 3'd0;
        for (int i = 0; i < 256; i++) begin
            ram[i] = 8'($urandom); em[i] = ram[i];
        end
        pc_r = 8'h10; exp_pc = 8'h10;
        poke_a(8'h5A);
        repeat (3) @(negedge clk);
        check("R9", "busy in reset", busy, 0);
        check("R9", "done in reset", done, 0);
        check("R9", "write in reset", mem_we, 0);
        rst = 1'b0;

        // Load immediate 0x80.
        poke_mem(8'h10, 8'h80);
        run_op(3'd4, 1'b0);
        check("R4", "immediate value", mem_addr, 8'h80);

        // Pointer to accumulator.
        poke_a(8'h00);
        run_op(3'd6, 1'b0);

        // Top wrap through accumulator load; 0x00 on the bus checks for no stray drive.
        poke_a(8'hFF);
        run_op(3'd5, 1'b0);
        poke_a(8'hC3);
        run_op(3'd0, 1'b0);
        check("R3", "increment wraps", mem_addr, 8'h00);
        run_op(3'd1, 1'b0);
        check("R3", "decrement wraps", mem_addr, 8'hFF);
        poke_a(8'h00);
        run_op(3'd5, 1'b0);
        check("R8", "bus value undisturbed", mem_addr, 8'h00);
        run_op(3'd1, 1'b0);
        check("R3", "pull from zero", mem_addr, 8'hFF);

        // Call then return.
        poke_a(8'h40);
        run_op(3'd5, 1'b0);
        pc_r = 8'h20; exp_pc = 8'h20;
        poke_mem(8'h20, 8'h90);
        run_op(3'd2, 1'b0);
        check("R6", "return address", ram[8'h40], 8'h21);
        check("R6", "jump target", pc_r, 8'h90);
        run_op(3'd3, 1'b0);
        check("R7", "restored pc", pc_r, 8'h21);

        // Start held while busy, then unused code.
        run_op(3'd1, 1'b1);
        @(negedge clk);
        start = 1'b1; op = 3'd7;
        @(negedge clk);
        start = 1'b0;
        check("R9", "unused code ignored", busy, 0);
        check("R9", "pointer after unused code", mem_addr, exp_sp);

        // Reset keeps the pointer.
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "pointer across reset", mem_addr, exp_sp);

        // Constrained random mix.
        for (int k = 0; k < 200; k++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 6));
            if ($urandom_range(0, 3) == 0) poke_a(8'($urandom));
            run_op(c, 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule